// File: doc/BRIEF.md
# Tri-Level Slow-Switch Monitor

This block watches three bidirectional slow-switch lines, named TV, VCR and AUX. Each line reaches the block as a 2-bit code from an external comparator that has already resolved the line into one of three levels. A line can be received or driven. A received line is filtered for a programmable number of clocks. Each accepted level goes into a packed status word. When the interrupt is enabled, any accepted change releases an open-drain interrupt line. That line stays released until software writes the enable bit low.

The block also decodes a per-line driver configuration into an output-enable and a level code for the line drivers. It also picks the source of the fast-switch output. That output can be held low, held high, or made to follow one of two fast-switch inputs: the encoder input or the VCR input. All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake.

Top module: `ssw_monitor`

## Requirements
- R1: After reset, `ssw_status` is 0, `irq_hiz` is 0, `drv_oe` is all ones, `drv_lvl` is 0, and the interrupt enable is off.
- R2: `ssw_status` packs one 2-bit field per line: TV in bits 1:0, VCR in bits 3:2 and AUX in bits 5:4. The same layout is used by `line_lvl`, `drv_cfg` and `drv_lvl`. Level codes are 00 for low, 01 for medium and 10 for high.
- R3: Suppose a received line's input moves to a new valid code and then holds it. The new code appears in `ssw_status` after exactly `stable_lim`+2 rising edges, counting the first edge that samples it. A new code that holds for fewer edges is never stored.
- R4: An input code of 11 is invalid. It is never stored, and it restarts the stability filter.
- R5: The status field of a line whose driver is enabled does not change, whatever that line's input does.
- R6: The `drv_cfg` field codes mean: 00 drive low, 01 drive medium, 10 high impedance, 11 drive high. One edge after a `drv_cfg` change, `drv_oe` is 0 for a line set to high impedance and 1 otherwise. In the same edge, `drv_lvl` takes the driven level code (00, 01 or 10), or 00 when the line is in high impedance.
- R7: While the interrupt is enabled, any change stored in `ssw_status` sets `irq_hiz` to 1 on the same edge as the status update.
- R8: Once `irq_hiz` is 1, it stays 1 even if the line later returns to its earlier level.
- R9: A cycle with `ctl_we`=1 and `ctl_irq_en`=0 clears `irq_hiz` and disables the interrupt. A cycle with `ctl_we`=1 and `ctl_irq_en`=1 enables the interrupt.
- R10: A status change stored while the interrupt is disabled leaves `irq_hiz` at 0.
- R11: `fs_out` is combinational in `fs_sel`: 00 gives 0, 01 follows `fs_enc_in`, 10 follows `fs_vcr_in`, and 11 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stable_lim | input | 8 | Extra stable clocks required before a level is accepted |
| line_lvl | input | 6 | Comparator level code per line |
| drv_cfg | input | 6 | Driver configuration per line |
| ctl_we | input | 1 | Write strobe for the interrupt enable bit |
| ctl_irq_en | input | 1 | Value written to the interrupt enable bit; writing 0 clears the interrupt |
| fs_sel | input | 2 | Fast-switch source select |
| fs_enc_in | input | 1 | Encoder fast-switch input |
| fs_vcr_in | input | 1 | VCR fast-switch input |
| drv_oe | output | 3 | Driver enable per line (0 = high impedance) |
| drv_lvl | output | 6 | Driven level code per line |
| ssw_status | output | 6 | Accepted level per line |
| irq_hiz | output | 1 | 1 = interrupt line released (interrupt asserted) |
| fs_out | output | 1 | Fast-switch output |

## Verification
The fast-switch select is walked through all four codes. Each code is tried with inputs that differ, so a swapped source or a stuck value shows up. The level filter is fed a held level, a pulse too short to pass, and the invalid code. It is also fed a level on a line that is being driven. Together these separate correct acceptance, glitch rejection and the gating by driver mode. The interrupt is exercised with the enable off, with the enable on and followed by a return to the old level, and across a clear. This shows that setting needs the enable and that the flag is sticky.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MED  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_BAD  = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    DRV_LOW  = 2'b00,
    DRV_MED  = 2'b01,
    DRV_HIZ  = 2'b10,
    DRV_HIGH = 2'b11
  } drv_e;

  typedef enum logic [1:0] {
    FS_FORCE0 = 2'b00,
    FS_ENC    = 2'b01,
    FS_VCR    = 2'b10,
    FS_FORCE1 = 2'b11
  } fs_sel_e;
endpackage

// File: rtl/ssw_line_filter.sv
module ssw_line_filter
  import ssw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hiz,
  input  logic [1:0]       raw,
  input  logic [CNT_W-1:0] lim,
  output logic [1:0]       status,
  output logic             upd
);
  logic [1:0]       cand_q;
  logic [1:0]       stat_q;
  logic [CNT_W-1:0] cnt_q;
  logic             raw_ok;

  assign raw_ok = (raw != LVL_BAD);
  assign upd    = hiz && raw_ok && (raw == cand_q) && (cnt_q >= lim) && (cand_q != stat_q);
  assign status = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= LVL_LOW;
      stat_q <= LVL_LOW;
      cnt_q  <= '0;
    end else if (!hiz || !raw_ok) begin
      cand_q <= stat_q;
      cnt_q  <= '0;
    end else if (raw != cand_q) begin
      cand_q <= raw;
      cnt_q  <= '0;
    end else if (upd) begin
      stat_q <= cand_q;
    end else if (cnt_q < lim) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  no_bad_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q != LVL_BAD);

  // R5
  only_when_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_q) |-> $past(hiz));
endmodule

// File: rtl/ssw_drive.sv
module ssw_drive
  import ssw_pkg::*;
#(
  parameter int NLINE = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*NLINE-1:0] cfg,
  output logic [NLINE-1:0]   oe,
  output logic [2*NLINE-1:0] lvl
);
  for (genvar i = 0; i < NLINE; i++) begin : g_drv
    logic [1:0] c;
    assign c = cfg[2*i +: 2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oe[i]        <= 1'b1;
        lvl[2*i +: 2] <= LVL_LOW;
      end else begin
        oe[i] <= (c != DRV_HIZ);
        unique case (c)
          DRV_LOW:  lvl[2*i +: 2] <= LVL_LOW;
          DRV_MED:  lvl[2*i +: 2] <= LVL_MED;
          DRV_HIGH: lvl[2*i +: 2] <= LVL_HIGH;
          default:  lvl[2*i +: 2] <= LVL_LOW;
        endcase
      end
    end

    // R6
    hiz_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg[2*i +: 2]) == DRV_HIZ) |-> !oe[i]);
  end
endmodule

// File: rtl/ssw_fs_mux.sv
module ssw_fs_mux
  import ssw_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       enc_in,
  input  logic       vcr_in,
  output logic       fs
);
  always_comb begin
    unique case (sel)
      FS_FORCE0: fs = 1'b0;
      FS_ENC:    fs = enc_in;
      FS_VCR:    fs = vcr_in;
      default:   fs = 1'b1;
    endcase
  end

  // R11
  always_comb begin
    force_low_chk: assert (!(sel == FS_FORCE0 && fs));
  end
endmodule

// File: rtl/ssw_monitor.sv
module ssw_monitor
  import ssw_pkg::*;
#(
  parameter int NLINE = 3,
  parameter int CNT_W = 8,
  localparam int SW   = 2 * NLINE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] stable_lim,
  input  logic [SW-1:0]    line_lvl,
  input  logic [SW-1:0]    drv_cfg,
  input  logic             ctl_we,
  input  logic             ctl_irq_en,
  input  logic [1:0]       fs_sel,
  input  logic             fs_enc_in,
  input  logic             fs_vcr_in,
  output logic [NLINE-1:0] drv_oe,
  output logic [SW-1:0]    drv_lvl,
  output logic [SW-1:0]    ssw_status,
  output logic             irq_hiz,
  output logic             fs_out
);
  logic [NLINE-1:0] upd;
  logic             any_upd;
  logic             en_q;
  logic             pend_q;
  logic             clr;

  ssw_drive #(.NLINE(NLINE)) u_drive (
    .clk  (clk),
    .rst_n(rst_n),
    .cfg  (drv_cfg),
    .oe   (drv_oe),
    .lvl  (drv_lvl)
  );

  for (genvar i = 0; i < NLINE; i++) begin : g_line
    ssw_line_filter #(.CNT_W(CNT_W)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .hiz   (!drv_oe[i]),
      .raw   (line_lvl[2*i +: 2]),
      .lim   (stable_lim),
      .status(ssw_status[2*i +: 2]),
      .upd   (upd[i])
    );
  end

  ssw_fs_mux u_fs (
    .sel   (fs_sel),
    .enc_in(fs_enc_in),
    .vcr_in(fs_vcr_in),
    .fs    (fs_out)
  );

  assign any_upd = |upd;
  assign clr     = ctl_we && !ctl_irq_en;
  assign irq_hiz = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ctl_we) en_q <= ctl_irq_en;
      if (clr)                  pend_q <= 1'b0;
      else if (en_q && any_upd) pend_q <= 1'b1;
    end
  end

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q);

  // R10
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(en_q));

  // R7
  irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !clr && !$stable(ssw_status)) |-> pend_q);
endmodule

// File: tb/ssw_monitor_bench.sv
`timescale 1ns/1ps
module ssw_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] stable_lim = 8'd3;
  logic [5:0] line_lvl = '0;
  logic [5:0] drv_cfg = '0;
  logic       ctl_we = 1'b0;
  logic       ctl_irq_en = 1'b0;
  logic [1:0] fs_sel = '0;
  logic       fs_enc_in = 1'b0;
  logic       fs_vcr_in = 1'b0;
  logic [2:0] drv_oe;
  logic [5:0] drv_lvl;
  logic [5:0] ssw_status;
  logic       irq_hiz;
  logic       fs_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ssw_monitor u_ssw_monitor (
    .clk(clk), .rst_n(rst_n), .stable_lim(stable_lim), .line_lvl(line_lvl),
    .drv_cfg(drv_cfg), .ctl_we(ctl_we), .ctl_irq_en(ctl_irq_en),
    .fs_sel(fs_sel), .fs_enc_in(fs_enc_in), .fs_vcr_in(fs_vcr_in),
    .drv_oe(drv_oe), .drv_lvl(drv_lvl), .ssw_status(ssw_status),
    .irq_hiz(irq_hiz), .fs_out(fs_out)
  );

  // {sel[1:0], enc, vcr, expected}
  localparam logic [4:0] FS_VEC [8] = '{
    5'b00_11_0, 5'b00_00_0, 5'b01_10_1, 5'b01_01_0,
    5'b10_10_0, 5'b10_01_1, 5'b11_00_1, 5'b11_11_1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_en(input logic v);
    ctl_we = 1'b1; ctl_irq_en = v;
    tick(1);
    ctl_we = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 status", ssw_status, 0);
    check("R1 irq", irq_hiz, 0);
    check("R1 oe", drv_oe, 3'b111);
    check("R1 lvl", drv_lvl, 0);

    // R11 fast-switch table
    for (int i = 0; i < 8; i++) begin
      {fs_sel, fs_enc_in, fs_vcr_in} = FS_VEC[i][4:1];
      #1;
      check("R11 fs_out", fs_out, FS_VEC[i][0]);
    end

    // R6 driver decode: TV hiz, VCR medium, AUX high
    drv_cfg = 6'b11_01_10;
    tick(1);
    check("R6 oe", drv_oe, 3'b110);
    check("R6 lvl", drv_lvl, 6'b10_01_00);

    // R5 driven VCR line ignored
    line_lvl = 6'b00_10_00;
    tick(10);
    check("R5 driven line", ssw_status, 0);

    // R3 short glitch on TV rejected
    line_lvl = 6'b00_10_10;
    tick(2);
    line_lvl = 6'b00_10_00;
    tick(10);
    check("R3 glitch", ssw_status, 0);

    // R2 / R10 high level accepted, irq disabled
    line_lvl = 6'b00_10_10;
    tick(10);
    check("R2 high code", ssw_status, 6'b00_00_10);
    check("R10 irq off", irq_hiz, 0);
    line_lvl = 6'b00_10_00;
    tick(10);
    check("R10 back low", ssw_status, 0);

    write_en(1'b1);
    check("R9 enable no set", irq_hiz, 0);

    // R4 invalid code ignored
    line_lvl = 6'b00_10_11;
    tick(10);
    check("R4 invalid", ssw_status, 0);
    check("R4 irq", irq_hiz, 0);

    // R3 exact timing, R7 irq set
    line_lvl = 6'b00_10_01;
    tick(4);
    check("R3 before limit", ssw_status, 0);
    check("R7 irq before", irq_hiz, 0);
    tick(1);
    check("R3 at limit", ssw_status, 6'b00_00_01);
    check("R7 irq set", irq_hiz, 1);

    // R8 sticky after return
    line_lvl = 6'b00_10_00;
    tick(10);
    check("R8 status back", ssw_status, 0);
    check("R8 sticky", irq_hiz, 1);

    // R9 clear and disable
    write_en(1'b0);
    check("R9 cleared", irq_hiz, 0);
    line_lvl = 6'b00_10_01;
    tick(10);
    check("R9 disabled status", ssw_status, 6'b00_00_01);
    check("R9 disabled irq", irq_hiz, 0);

    // R5 / R7 VCR switched to receive
    write_en(1'b1);
    drv_cfg = 6'b11_10_10;
    tick(10);
    check("R5 vcr received", ssw_status, 6'b00_10_01);
    check("R7 vcr irq", irq_hiz, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule